// File: doc/BRIEF.md
# Posted-Write Data Parity Error Handler

This block handles data parity errors on posted memory writes that pass through a two-port bus bridge, in both directions. On whichever bus the bridge is the target of a posted write, it checks even parity over the 32 address/data bits, the 4 byte-enable bits and the parity bit. That parity bit arrives one clock after its data phase. When the check fails, the block signals the error on that bus, sets a sticky status bit, and hands a one-bit bad-parity tag to the write buffer entry that holds the data. The transfer itself still completes normally.

When buffered data is later driven onto the opposite bus, the block generates outgoing parity from the data and the tag. A tagged data phase therefore leaves with wrong parity on purpose, and the error travels with the data. On the secondary bus the block also watches the error line driven by the downstream target. It records such reports and raises a system error on the primary side, but only for errors that started on the secondary bus, never for errors the bridge forwarded itself.

Top module: `posted_wr_parity`

## Requirements
- R1: A primary target data phase (`p_dphase_i` high at edge n) with a parity mismatch at edge n+1, where `p_par_i` differs from the XOR of `p_ad_i` and `p_cbe_i`, drives `p_perr_no` low for the single cycle after edge n+2. This happens only if `p_pe_en_i` is high at edge n+2.
- R2: The same rule applies on the secondary side with `s_dphase_i`, `s_ad_i`, `s_cbe_i`, `s_par_i` and `s_perr_no`, gated by `s_pe_en_i`, which is the secondary enable taken from bridge control.
- R3: Each detected error sets its parity-error-detected status bit at edge n+2, whatever the enables. Primary errors set `stat_o[0]` and secondary errors set `stat_o[1]`.
- R4: After edge n+1, the tag strobe for that direction is high for one cycle, and the tag carries the mismatch result: `dn_tag_we_o`/`dn_tag_o` for primary phases, `up_tag_we_o`/`up_tag_o` for secondary phases. The tag is never high without its strobe.
- R5: An outgoing data phase at edge m (`dn_out_vld_i` toward the secondary bus, `up_out_vld_i` toward the primary bus) produces, after edge m, a parity output (`s_par_o` or `p_par_o`) equal to the XOR of its data, its byte enables and its tag. The output is 0 when no phase is valid.
- R6: If `s_perr_ni` is sampled low at edge m+2 after a downstream outgoing phase at edge m, `stat_o[2]` is set at edge m+2, but only when `s_pe_en_i` is high.
- R7: In that same event, `p_serr_no` goes low for the cycle after edge m+2 and `stat_o[3]` is set, but only when all of these hold: `serr_en_i` is high, `pw_serr_dis_i` is low, and both `p_pe_en_i` and `s_pe_en_i` are high.
- R8: A far-side error report against a phase that was sent with its tag set never produces a system error, and it does not set `stat_o[3]`.
- R9: Status bits are sticky. A 1 in `stat_clr_i` clears the matching bit at the next edge, and a set in the same cycle wins over the clear.
- R10: During reset, both error outputs and `p_serr_no` are high, and `stat_o`, both tag strobes, both tags and both parity outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_pe_en_i | input | 1 | Primary parity response enable |
| s_pe_en_i | input | 1 | Secondary parity response enable |
| serr_en_i | input | 1 | System error enable |
| pw_serr_dis_i | input | 1 | Posted-write parity system-error disable |
| p_dphase_i | input | 1 | Primary posted-write data phase, bridge as target |
| p_ad_i | input | 32 | Primary data |
| p_cbe_i | input | 4 | Primary byte enables |
| p_par_i | input | 1 | Primary parity, one clock after data |
| p_perr_no | output | 1 | Primary parity error, active low |
| dn_tag_we_o | output | 1 | Downstream buffer tag strobe |
| dn_tag_o | output | 1 | Downstream bad-parity tag |
| s_dphase_i | input | 1 | Secondary posted-write data phase, bridge as target |
| s_ad_i | input | 32 | Secondary data |
| s_cbe_i | input | 4 | Secondary byte enables |
| s_par_i | input | 1 | Secondary parity, one clock after data |
| s_perr_no | output | 1 | Secondary parity error, active low |
| up_tag_we_o | output | 1 | Upstream buffer tag strobe |
| up_tag_o | output | 1 | Upstream bad-parity tag |
| dn_out_vld_i | input | 1 | Downstream data phase driven on secondary |
| dn_out_ad_i | input | 32 | Downstream outgoing data |
| dn_out_cbe_i | input | 4 | Downstream outgoing byte enables |
| dn_out_tag_i | input | 1 | Tag of the outgoing downstream entry |
| s_par_o | output | 1 | Generated secondary parity |
| s_perr_ni | input | 1 | Error line from the secondary target, active low |
| up_out_vld_i | input | 1 | Upstream data phase driven on primary |
| up_out_ad_i | input | 32 | Upstream outgoing data |
| up_out_cbe_i | input | 4 | Upstream outgoing byte enables |
| up_out_tag_i | input | 1 | Tag of the outgoing upstream entry |
| p_par_o | output | 1 | Generated primary parity |
| p_serr_no | output | 1 | Primary system error, active low |
| stat_clr_i | input | 4 | Write-one-to-clear for status bits |
| stat_o | output | 4 | Status: 0 primary detected, 1 secondary detected, 2 secondary data parity reported, 3 system error signalled |

## Verification
Each failure mode shows up at the ports within a few clocks.

- **Lost or misaligned parity pipeline stage.** The tag strobe moves off edge n+1, or the error pulse moves off edge n+2, and the bench sees either one on the first errored phase.
- **Stale outgoing tag or data.** The generated parity goes wrong one clock after the affected outgoing phase.
- **Far-side delay line out of step.** The tag used for the far-side report is taken from the wrong phase. A system error then appears for a forwarded error, or is missing for a local one, within three cycles of the report.
- **Corrupted status register.** A bad status bit stays visible on `stat_o` until it is cleared, so a sticky or clear defect persists across every later comparison.

// File: rtl/pwpe_pkg.sv
package pwpe_pkg;
  localparam int unsigned STAT_W   = 4;
  localparam int unsigned ST_P_PED = 0;
  localparam int unsigned ST_S_PED = 1;
  localparam int unsigned ST_S_DPD = 2;
  localparam int unsigned ST_P_SSE = 3;

  typedef struct packed {
    logic we;
    logic bad;
  } tag_t;
endpackage

// File: rtl/pwpe_par_chk.sv
module pwpe_par_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dphase_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              par_i,
  input  logic              pe_en_i,
  output pwpe_pkg::tag_t    tag_o,
  output logic              det_o,
  output logic              perr_no
);
  logic pend_q, dpar_q, err_q, we_q, perr_q;

  // stage 1: data parity, stage 2: compare with late PAR, stage 3: PERR#
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dpar_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b0;
      perr_q <= 1'b1;
    end else begin
      pend_q <= dphase_i;
      dpar_q <= ^{ad_i, cbe_i};
      err_q  <= pend_q & (dpar_q ^ par_i);
      we_q   <= pend_q;
      perr_q <= ~(err_q & pe_en_i);
    end
  end

  assign tag_o.we  = we_q;
  assign tag_o.bad = err_q;
  assign det_o     = err_q;
  assign perr_no   = perr_q;

  AST_PERR_AFTER_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(dphase_i, 3)); // R1
  AST_TAG_WE_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o.we |-> $past(dphase_i, 2)); // R4
  AST_TAG_NEEDS_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o.bad |-> tag_o.we); // R4
endmodule

// File: rtl/pwpe_par_gen.sv
module pwpe_par_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              tag_i,
  output logic              par_o
);
  logic par_q;

  // tagged entries leave with inverted parity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= vld_i & (^{ad_i, cbe_i} ^ tag_i);
  end

  assign par_o = par_q;
endmodule

// File: rtl/pwpe_far_mon.sv
module pwpe_far_mon #(
  parameter int unsigned RPT_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic tag_i,
  input  logic perr_ni,
  input  logic s_pe_en_i,
  input  logic p_pe_en_i,
  input  logic serr_en_i,
  input  logic serr_dis_i,
  output logic dpd_set_o,
  output logic sse_set_o,
  output logic serr_no
);
  logic [RPT_DLY-1:0] vld_sr, tag_sr;
  logic               hit, serr_q;

  generate
    if (RPT_DLY == 1) begin : g_d1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_sr <= '0;
          tag_sr <= '0;
        end else begin
          vld_sr <= vld_i;
          tag_sr <= tag_i;
        end
      end
    end else begin : g_dn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_sr <= '0;
          tag_sr <= '0;
        end else begin
          vld_sr <= {vld_sr[RPT_DLY-2:0], vld_i};
          tag_sr <= {tag_sr[RPT_DLY-2:0], tag_i};
        end
      end
    end
  endgenerate

  // report lines up with the phase RPT_DLY edges earlier
  assign hit       = vld_sr[RPT_DLY-1] & ~perr_ni;
  assign dpd_set_o = hit & s_pe_en_i;
  assign sse_set_o = hit & serr_en_i & ~serr_dis_i & s_pe_en_i & p_pe_en_i
                   & ~tag_sr[RPT_DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b1;
    else         serr_q <= ~sse_set_o;
  end

  assign serr_no = serr_q;

  AST_SERR_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(serr_en_i && !serr_dis_i && s_pe_en_i && p_pe_en_i)); // R7
  AST_SERR_NEEDS_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> !$past(perr_ni)); // R7
  AST_SERR_NOT_FORWARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> !$past(tag_i, 3)); // R8
  AST_DPD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dpd_set_o |-> s_pe_en_i); // R6
endmodule

// File: rtl/pwpe_stat.sv
module pwpe_stat #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[g]) bit_q <= 1'b1;
        else if (clr_i[g]) bit_q <= 1'b0;
      end
      assign stat_o[g] = bit_q;

      AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(stat_o[g]) && !$past(clr_i[g])) |-> stat_o[g]); // R9
      AST_STAT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(set_i[g]) |-> stat_o[g]); // R9
    end
  endgenerate
endmodule

// File: rtl/posted_wr_parity.sv
module posted_wr_parity #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        p_pe_en_i,
  input  logic                        s_pe_en_i,
  input  logic                        serr_en_i,
  input  logic                        pw_serr_dis_i,
  input  logic                        p_dphase_i,
  input  logic [DATA_W-1:0]           p_ad_i,
  input  logic [BE_W-1:0]             p_cbe_i,
  input  logic                        p_par_i,
  output logic                        p_perr_no,
  output logic                        dn_tag_we_o,
  output logic                        dn_tag_o,
  input  logic                        s_dphase_i,
  input  logic [DATA_W-1:0]           s_ad_i,
  input  logic [BE_W-1:0]             s_cbe_i,
  input  logic                        s_par_i,
  output logic                        s_perr_no,
  output logic                        up_tag_we_o,
  output logic                        up_tag_o,
  input  logic                        dn_out_vld_i,
  input  logic [DATA_W-1:0]           dn_out_ad_i,
  input  logic [BE_W-1:0]             dn_out_cbe_i,
  input  logic                        dn_out_tag_i,
  output logic                        s_par_o,
  input  logic                        s_perr_ni,
  input  logic                        up_out_vld_i,
  input  logic [DATA_W-1:0]           up_out_ad_i,
  input  logic [BE_W-1:0]             up_out_cbe_i,
  input  logic                        up_out_tag_i,
  output logic                        p_par_o,
  output logic                        p_serr_no,
  input  logic [pwpe_pkg::STAT_W-1:0] stat_clr_i,
  output logic [pwpe_pkg::STAT_W-1:0] stat_o
);
  import pwpe_pkg::*;

  localparam int unsigned RPT_DLY = 2;

  tag_t              dn_tag, up_tag;
  logic              p_det, s_det, dpd_set, sse_set;
  logic [STAT_W-1:0] stat_set;

  pwpe_par_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk_p (
    .clk_i, .rst_ni,
    .dphase_i (p_dphase_i), .ad_i (p_ad_i), .cbe_i (p_cbe_i), .par_i (p_par_i),
    .pe_en_i  (p_pe_en_i),  .tag_o (dn_tag), .det_o (p_det), .perr_no (p_perr_no)
  );

  pwpe_par_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk_s (
    .clk_i, .rst_ni,
    .dphase_i (s_dphase_i), .ad_i (s_ad_i), .cbe_i (s_cbe_i), .par_i (s_par_i),
    .pe_en_i  (s_pe_en_i),  .tag_o (up_tag), .det_o (s_det), .perr_no (s_perr_no)
  );

  pwpe_par_gen #(.DATA_W(DATA_W), .BE_W(BE_W)) u_gen_s (
    .clk_i, .rst_ni,
    .vld_i (dn_out_vld_i), .ad_i (dn_out_ad_i), .cbe_i (dn_out_cbe_i),
    .tag_i (dn_out_tag_i), .par_o (s_par_o)
  );

  pwpe_par_gen #(.DATA_W(DATA_W), .BE_W(BE_W)) u_gen_p (
    .clk_i, .rst_ni,
    .vld_i (up_out_vld_i), .ad_i (up_out_ad_i), .cbe_i (up_out_cbe_i),
    .tag_i (up_out_tag_i), .par_o (p_par_o)
  );

  pwpe_far_mon #(.RPT_DLY(RPT_DLY)) u_far (
    .clk_i, .rst_ni,
    .vld_i      (dn_out_vld_i), .tag_i     (dn_out_tag_i), .perr_ni (s_perr_ni),
    .s_pe_en_i  (s_pe_en_i),    .p_pe_en_i (p_pe_en_i),    .serr_en_i (serr_en_i),
    .serr_dis_i (pw_serr_dis_i),
    .dpd_set_o  (dpd_set),      .sse_set_o (sse_set),      .serr_no (p_serr_no)
  );

  always_comb begin
    stat_set           = '0;
    stat_set[ST_P_PED] = p_det;
    stat_set[ST_S_PED] = s_det;
    stat_set[ST_S_DPD] = dpd_set;
    stat_set[ST_P_SSE] = sse_set;
  end

  pwpe_stat #(.W(STAT_W)) u_stat (
    .clk_i, .rst_ni, .set_i (stat_set), .clr_i (stat_clr_i), .stat_o (stat_o)
  );

  assign dn_tag_we_o = dn_tag.we;
  assign dn_tag_o    = dn_tag.bad;
  assign up_tag_we_o = up_tag.we;
  assign up_tag_o    = up_tag.bad;

  AST_SSE_WITH_SERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_serr_no |-> stat_o[ST_P_SSE]); // R7
  AST_PED_WITH_PERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_perr_no |-> stat_o[ST_P_PED]); // R3
endmodule

// File: tb/sim_posted_wr_parity.sv
module sim_posted_wr_parity;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic p_pe_en, s_pe_en, serr_en, serr_dis;
  logic p_dph, p_par, s_dph, s_par;
  logic [31:0] p_ad, s_ad, dn_ad, up_ad;
  logic [3:0]  p_cbe, s_cbe, dn_cbe, up_cbe, clr;
  logic dn_vld, dn_tag_in, up_vld, up_tag_in, s_perr_in_n;
  logic p_perr_n, s_perr_n, dn_we, dn_tg, up_we, up_tg, s_par_out, p_par_out, p_serr_n;
  logic [3:0] stat;

  posted_wr_parity u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .p_pe_en_i(p_pe_en), .s_pe_en_i(s_pe_en), .serr_en_i(serr_en), .pw_serr_dis_i(serr_dis),
    .p_dphase_i(p_dph), .p_ad_i(p_ad), .p_cbe_i(p_cbe), .p_par_i(p_par), .p_perr_no(p_perr_n),
    .dn_tag_we_o(dn_we), .dn_tag_o(dn_tg),
    .s_dphase_i(s_dph), .s_ad_i(s_ad), .s_cbe_i(s_cbe), .s_par_i(s_par), .s_perr_no(s_perr_n),
    .up_tag_we_o(up_we), .up_tag_o(up_tg),
    .dn_out_vld_i(dn_vld), .dn_out_ad_i(dn_ad), .dn_out_cbe_i(dn_cbe), .dn_out_tag_i(dn_tag_in),
    .s_par_o(s_par_out), .s_perr_ni(s_perr_in_n),
    .up_out_vld_i(up_vld), .up_out_ad_i(up_ad), .up_out_cbe_i(up_cbe), .up_out_tag_i(up_tag_in),
    .p_par_o(p_par_out), .p_serr_no(p_serr_n), .stat_clr_i(clr), .stat_o(stat)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model: history of what happened, evaluated per edge
  bit e_p_perr, e_s_perr, e_dn_we, e_dn_tg, e_up_we, e_up_tg, e_s_par, e_p_par, e_serr;
  bit [3:0] e_stat;
  bit ph_p[$], pd_p[$], er_p[$], ph_s[$], pd_s[$], er_s[$], dv[$], dt[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {e_dn_we, e_dn_tg, e_up_we, e_up_tg, e_s_par, e_p_par} = '0;
      {e_p_perr, e_s_perr, e_serr} = 3'b111;
      e_stat = '0;
      ph_p = {0}; pd_p = {0}; er_p = {0}; ph_s = {0}; pd_s = {0}; er_s = {0};
      dv = {0, 0}; dt = {0, 0};
    end else begin
      bit ep, es, hit, sse;
      bit [3:0] set;
      ep = ph_p[$] && (pd_p[$] != p_par);
      es = ph_s[$] && (pd_s[$] != s_par);
      e_dn_we = ph_p[$]; e_dn_tg = ep;
      e_up_we = ph_s[$]; e_up_tg = es;
      e_p_perr = !(er_p[$] && p_pe_en);
      e_s_perr = !(er_s[$] && s_pe_en);
      hit = dv[0] && !s_perr_in_n;
      sse = hit && serr_en && !serr_dis && s_pe_en && p_pe_en && !dt[0];
      e_serr = !sse;
      set = {sse, hit && s_pe_en, er_s[$], er_p[$]};
      e_stat = (e_stat & ~clr) | set;
      e_s_par = dn_vld && ((^{dn_ad, dn_cbe}) ^ dn_tag_in);
      e_p_par = up_vld && ((^{up_ad, up_cbe}) ^ up_tag_in);
      er_p.push_back(ep); void'(er_p.pop_front());
      er_s.push_back(es); void'(er_s.pop_front());
      ph_p.push_back(p_dph); void'(ph_p.pop_front());
      pd_p.push_back(^{p_ad, p_cbe}); void'(pd_p.pop_front());
      ph_s.push_back(s_dph); void'(ph_s.pop_front());
      pd_s.push_back(^{s_ad, s_cbe}); void'(pd_s.pop_front());
      dv.push_back(dn_vld); void'(dv.pop_front());
      dt.push_back(dn_tag_in); void'(dt.pop_front());
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(rst_n ? "R1 p_perr" : "R10 p_perr", p_perr_n, e_p_perr);
    chk(rst_n ? "R2 s_perr" : "R10 s_perr", s_perr_n, e_s_perr);
    chk("R4 dn_we", dn_we, e_dn_we);
    chk("R4 dn_tag", dn_tg, e_dn_tg);
    chk("R4 up_we", up_we, e_up_we);
    chk("R4 up_tag", up_tg, e_up_tg);
    chk("R5 s_par", s_par_out, e_s_par);
    chk("R5 p_par", p_par_out, e_p_par);
    chk("R7 R8 p_serr", p_serr_n, e_serr);
    chk("R3 R9 stat0", stat[0], e_stat[0]);
    chk("R3 R9 stat1", stat[1], e_stat[1]);
    chk("R6 R9 stat2", stat[2], e_stat[2]);
    chk("R7 R8 R9 stat3", stat[3], e_stat[3]);
  end

  task automatic idle();
    {p_dph, s_dph, dn_vld, up_vld, dn_tag_in, up_tag_in} = '0;
    {p_par, s_par} = '0; s_perr_in_n = 1'b1; clr = '0;
    p_ad = '0; s_ad = '0; dn_ad = '0; up_ad = '0;
    p_cbe = '0; s_cbe = '0; dn_cbe = '0; up_cbe = '0;
  endtask

  task automatic rnd_cycle(int err_pct, int rpt_pct);
    @(negedge clk);
    // PAR belongs to the previous phase
    p_par = (^{p_ad, p_cbe}) ^ ($urandom_range(99) < err_pct);
    s_par = (^{s_ad, s_cbe}) ^ ($urandom_range(99) < err_pct);
    p_dph = $urandom_range(1); s_dph = $urandom_range(1);
    p_ad = $urandom; p_cbe = $urandom; s_ad = $urandom; s_cbe = $urandom;
    dn_vld = $urandom_range(1); dn_ad = $urandom; dn_cbe = $urandom;
    dn_tag_in = $urandom_range(3) == 0;
    up_vld = $urandom_range(1); up_ad = $urandom; up_cbe = $urandom;
    up_tag_in = $urandom_range(3) == 0;
    s_perr_in_n = !($urandom_range(99) < rpt_pct);
    clr = ($urandom_range(15) == 0) ? 4'($urandom) : 4'b0;
  endtask

  // R8 directed: forwarded phase reported by far target, all enables on
  task automatic far_report(bit tag);
    @(negedge clk); idle(); dn_vld = 1'b1; dn_ad = 32'hA5A5_0001; dn_cbe = 4'h3; dn_tag_in = tag;
    @(negedge clk); idle();
    @(negedge clk); idle(); s_perr_in_n = 1'b0;
    @(negedge clk); idle();
    @(negedge clk); idle(); clr = 4'hF;
    @(negedge clk); idle();
  endtask

  initial begin
    idle(); p_pe_en = 1; s_pe_en = 1; serr_en = 1; serr_dis = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); idle();
    // R1 single errored primary phase, enable on then off
    @(negedge clk); p_dph = 1; p_ad = 32'h0000_0001; p_cbe = 4'h0;
    @(negedge clk); p_dph = 0; p_par = 1'b0;
    repeat (3) @(negedge clk); clr = 4'hF; @(negedge clk); clr = '0;
    p_pe_en = 0;
    @(negedge clk); s_dph = 1; s_ad = 32'h3; s_cbe = 4'h1;
    @(negedge clk); s_dph = 0; s_par = 1'b0;
    repeat (4) @(negedge clk);
    p_pe_en = 1;
    far_report(1'b0);
    far_report(1'b1);
    for (int seg = 0; seg < 32; seg++) begin
      p_pe_en = $urandom_range(3) != 0; s_pe_en = $urandom_range(3) != 0;
      serr_en = $urandom_range(3) != 0; serr_dis = $urandom_range(3) == 0;
      for (int i = 0; i < 100; i++) rnd_cycle(30, 30);
    end
    @(negedge clk); idle();
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule